// File: doc/BRIEF.md
# 4-Bit ALU with Carry and Status Flags

This block is the arithmetic and logic datapath of a very small 4-bit controller. Each cycle it takes an operation code, the accumulator value, a second operand and a bit index. The second operand comes from data memory, from an immediate field or from the pointer register. The block returns the 4-bit result on the same cycle. It owns the carry flag (CF) and the status flag (SF) and updates both at the clock edge whenever an operation is issued.

SF is the only condition the conditional jump can test, so each operation class has its own SF rule:

- Additions and increments write the inverted carry.
- Reverse subtraction and decrements write the plain carry, which means "no borrow".
- Logic operations write "result is not zero".
- Bit tests write the inverted bit.
- Loads and register transfers force SF to one.

Only add-with-carry and reverse subtract with borrow write CF from the arithmetic. The two carry-control operations set or clear CF directly.

The surrounding controller drives `op_valid` for one cycle per issued operation. It takes `result` for write-back and uses `branch_taken` to redirect its program counter.

Top module: `alu4_sf_core`

## Requirements
- R1: Code 1 (add with carry) gives result = (A + M + CF) mod 16, loads CF with the carry out of bit 3, and sets SF to the inverse of that carry.
- R2: Codes 2, 3 and 4 (add memory, add immediate, add to pointer) give result = (A + M) mod 16, set SF to the inverse of the carry out, and leave CF unchanged.
- R3: Code 5 (reverse subtract with borrow) gives result = (M - A - (1 - CF)) mod 16, sets CF to 1 exactly when no borrow occurs, and sets SF equal to the new CF.
- R4: Code 6 (increment) gives (M + 1) mod 16 with SF = 0 only when M = 15. Code 7 (decrement) gives (M - 1) mod 16 with SF = 0 only when M = 0. Both leave CF unchanged.
- R5: Codes 8, 9 and 10 (AND, OR, XOR of A and M) set SF to 1 when the result is non-zero and to 0 when it is zero, and leave CF unchanged.
- R6: Code 11 (load) gives result = M, forces SF to 1 and leaves CF unchanged.
- R7: Codes 12 and 13 give M with bit `bit_sel` (0 to 3) cleared or set, force SF to 1 and leave CF unchanged.
- R8: Code 14 (bit test) gives result = M, sets SF to 0 when bit `bit_sel` of M is 1 and to 1 when it is 0, and leaves CF unchanged.
- R9: Code 15 clears CF, code 16 sets CF, and both force SF to 1. Code 17 copies CF into SF and leaves CF unchanged.
- R10: Code 18 (conditional jump) drives `branch_taken` high in its cycle only when SF is 1, then forces SF to 1 and leaves CF unchanged. `branch_taken` is low for every other code and whenever `op_valid` is low.
- R11: A clock edge with `rst_n` low sets CF to 0 and SF to 1.
- R12: Code 0, codes 19 to 31, and any cycle with `op_valid` low leave both flags unchanged. For codes 0, 15 to 31, `result` equals A.
- R13: `cf_next` and `sf_next` show, in the same cycle, the values CF and SF take at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| acc_in | input | 4 | Accumulator operand A, or the pointer for code 4 |
| opnd_in | input | 4 | Memory or immediate operand M |
| bit_sel | input | 2 | Bit index for codes 12 to 14 |
| result | output | 4 | Combinational operation result |
| cf | output | 1 | Registered carry flag |
| sf | output | 1 | Registered status flag |
| cf_next | output | 1 | Value CF takes at the next edge |
| sf_next | output | 1 | Value SF takes at the next edge |
| branch_taken | output | 1 | Conditional jump taken this cycle |

## Verification
The flags are the only state in the block, and both are visible at the ports one edge after every update. A wrong flag rule shows up on `cf_next` or `sf_next` in the cycle of the offending operation, and on `cf` or `sf` one cycle later. A flag that is corrupted without being rewritten shows its effect later and more indirectly: a later add-with-carry or subtract gives a result off by one, a carry-test copies the wrong value, or a jump is taken or skipped. The bench therefore runs mixed streams in which stale flag values feed into later operations. Those streams include undefined codes and idle cycles between operations, to expose flags that change when they should hold.

// File: rtl/alu4_sf_pkg.sv
// Shared operation codes for the 4-bit ALU with carry/status flags.
// Assumes a 5-bit opcode field; codes above OP_BRANCH are undefined.
package alu4_sf_pkg;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_ADDC   = 5'd1,
        OP_ADDM   = 5'd2,
        OP_ADDI   = 5'd3,
        OP_ADDP   = 5'd4,
        OP_SUBRC  = 5'd5,
        OP_INC    = 5'd6,
        OP_DEC    = 5'd7,
        OP_AND    = 5'd8,
        OP_OR     = 5'd9,
        OP_XOR    = 5'd10,
        OP_LOAD   = 5'd11,
        OP_BCLR   = 5'd12,
        OP_BSET   = 5'd13,
        OP_BTEST  = 5'd14,
        OP_CLRC   = 5'd15,
        OP_SETC   = 5'd16,
        OP_TESTC  = 5'd17,
        OP_BRANCH = 5'd18
    } op_t;

    localparam logic [4:0] OP_LAST = 5'd18;

    typedef struct packed {
        logic cf;
        logic sf;
    } flags_t;

endpackage

// File: rtl/alu4_adder.sv
// Shared adder for every arithmetic opcode.
// Chooses the two operands and the carry-in from the opcode, then runs one
// DW+1-bit addition. The carry out means "carry" for additions and
// "no borrow" for subtraction and decrement.
// Assumes non-arithmetic opcodes ignore the outputs.
module alu4_adder
    import alu4_sf_pkg::*;
#(
    parameter int DW = 4
) (
    input  op_t           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout
);
    localparam int SW = DW + 1;

    logic [DW-1:0] x, y;
    logic          c;
    logic [SW-1:0] total;

    // Operand and carry-in selection per arithmetic opcode
    always_comb begin
        x = a;
        y = m;
        c = 1'b0;
        case (op)
            OP_ADDC:  c = cin;
            OP_SUBRC: begin x = m; y = ~a; c = cin; end
            OP_INC:   begin x = m; y = '0; c = 1'b1; end
            OP_DEC:   begin x = m; y = '1; c = 1'b0; end
            default:  ;
        endcase
    end

    // Single carry-propagate addition
    always_comb begin
        total = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
        sum   = total[DW-1:0];
        cout  = total[DW];
    end

endmodule

// File: rtl/alu4_bitlogic.sv
// Logic and single-bit datapath.
// Forms AND/OR/XOR of the two operands, clears or sets one bit of the
// memory operand, and extracts the bit tested by the bit-test opcode.
// Assumes bit_idx < DW.
module alu4_bitlogic
    import alu4_sf_pkg::*;
#(
    parameter int DW = 4,
    localparam int IW = (DW > 1) ? $clog2(DW) : 1
) (
    input  op_t           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic [IW-1:0] bit_idx,
    output logic [DW-1:0] res,
    output logic          bit_val
);
    logic [DW-1:0] mask;

    // One-hot mask decode, one comparator per bit position
    generate
        for (genvar i = 0; i < DW; i++) begin : g_mask
            assign mask[i] = (bit_idx == IW'(i));
        end
    endgenerate

    // Selected bit of the memory operand
    assign bit_val = |(m & mask);

    // Logic and bit-modify result
    always_comb begin
        case (op)
            OP_AND:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_BCLR: res = m & ~mask;
            OP_BSET: res = m | mask;
            default: res = m;
        endcase
    end

endmodule

// File: rtl/alu4_flag_unit.sv
// Carry and status flag registers with the per-class update rules.
// cf_d/sf_d are the next-state values, exported for look-ahead.
// Assumes synchronous active-low reset: CF clears, SF sets.
module alu4_flag_unit
    import alu4_sf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  op_t  op,
    input  logic carry,
    input  logic zero,
    input  logic bit_val,
    output logic cf_q,
    output logic sf_q,
    output logic cf_d,
    output logic sf_d
);
    flags_t cur, nxt;

    assign cur  = '{cf: cf_q, sf: sf_q};
    assign cf_d = nxt.cf;
    assign sf_d = nxt.sf;

    // Next-state rule for each operation class
    always_comb begin
        nxt = cur;
        if (op_valid) begin
            case (op)
                OP_ADDC:  begin nxt.cf = carry; nxt.sf = ~carry; end
                OP_ADDM, OP_ADDI, OP_ADDP, OP_INC:
                          nxt.sf = ~carry;
                OP_SUBRC: begin nxt.cf = carry; nxt.sf = carry; end
                OP_DEC:   nxt.sf = carry;
                OP_AND, OP_OR, OP_XOR:
                          nxt.sf = ~zero;
                OP_LOAD, OP_BCLR, OP_BSET, OP_BRANCH:
                          nxt.sf = 1'b1;
                OP_BTEST: nxt.sf = ~bit_val;
                OP_CLRC:  begin nxt.cf = 1'b0; nxt.sf = 1'b1; end
                OP_SETC:  begin nxt.cf = 1'b1; nxt.sf = 1'b1; end
                OP_TESTC: nxt.sf = cur.cf;
                default:  ;
            endcase
        end
    end

    // Flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cf_q <= 1'b0;
            sf_q <= 1'b1;
        end else begin
            cf_q <= nxt.cf;
            sf_q <= nxt.sf;
        end
    end

endmodule

// File: rtl/alu4_sf_core.sv
// Top of the 4-bit ALU: combinational result, registered CF/SF,
// and the conditional-jump decision.
// Assumes one operation per cycle, qualified by op_valid. The result is
// produced from op_code regardless of op_valid.
module alu4_sf_core
    import alu4_sf_pkg::*;
#(
    parameter int DW = 4,
    localparam int IW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [IW-1:0] bit_sel,
    output logic [DW-1:0] result,
    output logic          cf,
    output logic          sf,
    output logic          cf_next,
    output logic          sf_next,
    output logic          branch_taken
);
    op_t           op;
    logic [DW-1:0] sum, lres;
    logic          carry, bit_val, zero;

    assign op = op_t'(op_code);

    alu4_adder #(.DW(DW)) u_adder (
        .op   (op),
        .a    (acc_in),
        .m    (opnd_in),
        .cin  (cf),
        .sum  (sum),
        .cout (carry)
    );

    alu4_bitlogic #(.DW(DW)) u_bitlogic (
        .op      (op),
        .a       (acc_in),
        .m       (opnd_in),
        .bit_idx (bit_sel),
        .res     (lres),
        .bit_val (bit_val)
    );

    // Result selection by operation class
    always_comb begin
        case (op)
            OP_ADDC, OP_ADDM, OP_ADDI, OP_ADDP,
            OP_SUBRC, OP_INC, OP_DEC:         result = sum;
            OP_AND, OP_OR, OP_XOR,
            OP_BCLR, OP_BSET:                 result = lres;
            OP_LOAD, OP_BTEST:                result = opnd_in;
            default:                          result = acc_in;
        endcase
    end

    // Zero detect for the logic-class status rule
    assign zero = (lres == '0);

    alu4_flag_unit u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op       (op),
        .carry    (carry),
        .zero     (zero),
        .bit_val  (bit_val),
        .cf_q     (cf),
        .sf_q     (sf),
        .cf_d     (cf_next),
        .sf_d     (sf_next)
    );

    // Conditional jump decision from the registered status flag
    assign branch_taken = op_valid && (op == OP_BRANCH) && sf;

endmodule

// File: rtl/alu4_sf_checker.sv
// Temporal properties of the flag behaviour, bound into alu4_sf_core.
// Assumes the port names of the core.
module alu4_sf_checker
    import alu4_sf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [4:0] op_code,
    input logic       cf,
    input logic       sf,
    input logic       cf_next,
    input logic       sf_next,
    input logic       branch_taken
);
    // R11
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!cf && sf));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 5'(OP_NOP) || op_code > OP_LAST)
        |=> ($stable(cf) && $stable(sf)));

    // R9
    cf_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(op_code inside {5'(OP_ADDC), 5'(OP_SUBRC), 5'(OP_CLRC), 5'(OP_SETC)}))
        |=> $stable(cf));

    // R9
    clr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'(OP_CLRC)) |=> (!cf && sf));

    // R9
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'(OP_SETC)) |=> (cf && sf));

    // R9
    test_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'(OP_TESTC)) |=> (sf == $past(cf)));

    // R10
    branch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> (sf && op_valid && op_code == 5'(OP_BRANCH)));

    // R6
    load_sf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'(OP_LOAD)) |=> sf);

    // R13
    lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cf == $past(cf_next) && sf == $past(sf_next)));

endmodule

bind alu4_sf_core alu4_sf_checker u_alu4_sf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .cf           (cf),
    .sf           (sf),
    .cf_next      (cf_next),
    .sf_next      (sf_next),
    .branch_taken (branch_taken)
);

// File: tb/alu4_sf_core_bench.sv
// Self-checking bench: behavioural flag/result model compared every clock.
module alu4_sf_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [3:0] acc_in = 4'd0;
    logic [3:0] opnd_in = 4'd0;
    logic [1:0] bit_sel = 2'd0;
    logic [3:0] result;
    logic       cf, sf, cf_next, sf_next, branch_taken;

    int checks = 0;
    int fails = 0;
    int mcf = 0;
    int msf = 1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu4_sf_core u_alu4_sf_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .bit_sel(bit_sel),
        .result(result), .cf(cf), .sf(sf), .cf_next(cf_next),
        .sf_next(sf_next), .branch_taken(branch_taken)
    );

    function automatic string req_of(int op, bit v);
        if (!v || op == 0 || op > 18) return "R12";
        case (op)
            1: return "R1";
            2, 3, 4: return "R2";
            5: return "R3";
            6, 7: return "R4";
            8, 9, 10: return "R5";
            11: return "R6";
            12, 13: return "R7";
            14: return "R8";
            15, 16, 17: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference for one operation
    task automatic model(input bit v, input int op, a, m, b,
                         output int res, ncf, nsf, tk);
        int s;
        res = a; ncf = mcf; nsf = msf; tk = 0;
        case (op)
            1: begin s = a + m + mcf; res = s % 16; ncf = (s > 15); nsf = !(s > 15); end
            2, 3, 4: begin s = a + m; res = s % 16; nsf = !(s > 15); end
            5: begin s = m - a - (1 - mcf); res = s & 15; ncf = (s >= 0); nsf = (s >= 0); end
            6: begin res = (m + 1) % 16; nsf = (m != 15); end
            7: begin res = (m + 15) % 16; nsf = (m != 0); end
            8: begin res = a & m; nsf = (res != 0); end
            9: begin res = a | m; nsf = (res != 0); end
            10: begin res = a ^ m; nsf = (res != 0); end
            11: begin res = m; nsf = 1; end
            12: begin res = m & ~(1 << b) & 15; nsf = 1; end
            13: begin res = (m | (1 << b)) & 15; nsf = 1; end
            14: begin res = m; nsf = ((m >> b) & 1) ? 0 : 1; end
            15: begin ncf = 0; nsf = 1; end
            16: begin ncf = 1; nsf = 1; end
            17: nsf = mcf;
            18: begin tk = msf; nsf = 1; end
            default: ;
        endcase
        if (!v) begin ncf = mcf; nsf = msf; tk = 0; end
    endtask

    task automatic step(input bit v, input int op, a, m, b);
        int res, ncf, nsf, tk;
        string t;
        @(negedge clk);
        chk("R11/R13", "cf", int'(cf), mcf);
        chk("R11/R13", "sf", int'(sf), msf);
        op_valid = v; op_code = 5'(op); acc_in = 4'(a); opnd_in = 4'(m); bit_sel = 2'(b);
        #1;
        model(v, op, a, m, b, res, ncf, nsf, tk);
        t = req_of(op, v);
        if (op <= 18 || !v) chk(t, "result", int'(result), res);
        else chk(t, "result", int'(result), a);
        chk(t, "cf_next", int'(cf_next), ncf);
        chk(t, "sf_next", int'(sf_next), nsf);
        chk("R10", "branch_taken", int'(branch_taken), tk);
        @(posedge clk);
        mcf = ncf; msf = nsf;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        @(posedge clk);
        mcf = 0; msf = 1;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11", "cf after reset", int'(cf), 0);
        chk("R11", "sf after reset", int'(sf), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset();
        step(1, 16, 0, 0, 0);       // R9 set carry
        step(1, 1, 15, 0, 0);       // R1 15+0+1 carries
        step(1, 1, 3, 4, 0);        // R1 no carry, CF in
        step(1, 2, 7, 8, 0);        // R2 no carry
        step(1, 3, 15, 1, 0);       // R2 carry, SF 0
        step(1, 4, 9, 9, 0);        // R2 pointer add
        step(1, 16, 0, 0, 0);
        step(1, 5, 3, 3, 0);        // R3 no borrow -> CF 1
        step(1, 15, 0, 0, 0);
        step(1, 5, 0, 0, 0);        // R3 borrow -> F, CF 0
        step(1, 6, 0, 15, 0);       // R4 inc wrap
        step(1, 7, 0, 0, 0);        // R4 dec wrap
        step(1, 7, 0, 5, 0);        // R4 dec plain
        step(1, 8, 10, 5, 0);       // R5 zero result
        step(1, 10, 6, 3, 0);       // R5 non-zero
        step(1, 11, 2, 9, 0);       // R6
        step(1, 12, 0, 15, 3);      // R7 clear bit 3
        step(1, 13, 0, 0, 1);       // R7 set bit 1
        step(1, 14, 0, 8, 3);       // R8 bit 1 -> SF 0
        step(1, 18, 0, 0, 0);       // R10 not taken, SF -> 1
        step(1, 18, 0, 0, 0);       // R10 taken
        step(1, 14, 0, 8, 2);       // R8 bit 0 -> SF 1
        step(1, 17, 0, 0, 0);       // R9 test carry
        step(1, 3, 15, 15, 0);      // SF 0
        step(1, 25, 4, 4, 0);       // R12 undefined code holds
        step(1, 0, 5, 5, 0);        // R12 nop
        step(0, 16, 1, 1, 0);       // R12 not issued
        step(0, 18, 1, 1, 0);
        for (int i = 0; i < 3000; i++) begin
            bit v;
            int op;
            v = ($urandom % 8) != 0;
            op = ($urandom % 5 == 0) ? int'($urandom % 32) : int'($urandom % 19);
            step(v, op, int'($urandom % 16), int'($urandom % 16), int'($urandom % 4));
            if (i == 1500) do_reset();
        end
        @(negedge clk);
        chk("R13", "final cf", int'(cf), mcf);
        chk("R13", "final sf", int'(sf), msf);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule